// File: doc/BRIEF.md
# Free-Running Timer Counter with Prescaler

This block is a 16-bit up-counter that never stops. It advances on a tick taken either from the system clock divided by 2, 4 or 8, or from an external input. The external input is synchronised and then edge-detected on a chosen polarity. Software reaches the count through a byte-wide register port that offers two views of the count. Reading the normal view takes part in clearing the overflow flag. Reading the alternate view never does.

The counter starts from FFFCh after reset. It is reloaded with FFFCh whenever software writes a low byte, and that write also restarts the divider. When the count wraps from FFFFh to 0000h, a status flag is set. That flag drives an interrupt line gated by an enable bit. Reading either high byte copies the low byte into a per-view shadow register, so a high-then-low read pair yields one coherent 16-bit value.

Top module: `freerun_timer`

## Requirements
- R1: While reset is asserted and on release, the count is FFFCh, the status byte reads 00h, the control byte reads 00h and irq_o is low.
- R2: With control bits [1:0] set to 00, 01 or 10, the count advances by one every 2, 4 or 8 clock cycles respectively. The divider restarts on every control write and every count reload, so the first advance comes one full divider period later.
- R3: A write to address 1 or address 3 loads FFFCh into the count whatever the data, and restarts the divider. A write to address 0 or address 2 leaves the count unchanged.
- R4: With control bits [1:0] = 11, the count advances once per active edge of ext_clk_i. Control bit 2 selects the edge: 0 for rising, 1 for falling. The other edge has no effect. The advance appears on the third rising clock edge after the input transition.
- R5: A wrap of the count from FFFFh to 0000h sets the overflow flag, which reads as bit 7 of the status byte at address 4.
- R6: The flag clears only when the status byte is read while the flag is set and address 1 is then read or written. A read of address 3 never clears it. An access to address 1 without that preceding status read leaves it set.
- R7: If the clearing access to address 1 and a wrap fall on the same clock edge, the flag stays set.
- R8: irq_o is high exactly when the overflow flag is set and control bit 3 is 1.
- R9: Reading the high byte of a view copies the current low byte into that view's shadow. The next low-byte read of the same view returns the copy, not the live count. Both views report the same count.
- R10: The register map is as follows. Address 0 is the normal high byte, address 1 the normal low byte, address 2 the alternate high byte, address 3 the alternate low byte, address 4 the status byte and address 5 the control byte. The control byte reads back bits [3:0] with the upper bits zero, and every other address reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count input, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_rd | input | 1 | Read qualifier; side effects happen at the clock edge |
| bus_wr | input | 1 | Write qualifier |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Two events can land on the same clock edge: the access to the normal low byte that clears the flag, and the wrap that sets it. The bench creates this collision on purpose. It arms the clear with a status read, then writes the alternate low byte to reload the count without disarming. It then counts clock cycles so that the normal low-byte read lands exactly on the edge where FFFFh rolls over. The flag must survive, which the bench judges through irq_o. A second, uncontested clearing sequence must then bring irq_o low.

// File: rtl/freerun_timer.sv
module freerun_timer #(
  parameter logic [15:0] RELOAD = 16'hFFFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk_i,
  input  logic       bus_sel,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o
);

  localparam logic [2:0] A_HI   = 3'd0;
  localparam logic [2:0] A_LO   = 3'd1;
  localparam logic [2:0] A_AHI  = 3'd2;
  localparam logic [2:0] A_ALO  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_CTRL = 3'd5;
  localparam logic [15:0] TOP   = '1;

  logic [15:0] cnt;
  logic [2:0]  div, div_last;
  logic [3:0]  ctrl;
  logic [2:0]  sync;
  logic        ovf_flag, armed;
  logic [7:0]  shd_n, shd_a;
  logic        vld_n, vld_a;

  wire rd_hi   = bus_sel && bus_rd && bus_addr == A_HI;
  wire rd_lo   = bus_sel && bus_rd && bus_addr == A_LO;
  wire rd_ahi  = bus_sel && bus_rd && bus_addr == A_AHI;
  wire rd_alo  = bus_sel && bus_rd && bus_addr == A_ALO;
  wire rd_stat = bus_sel && bus_rd && bus_addr == A_STAT;
  wire wr_ctrl = bus_sel && bus_wr && bus_addr == A_CTRL;
  wire wr_lo   = bus_sel && bus_wr && bus_addr == A_LO;
  wire wr_alo  = bus_sel && bus_wr && bus_addr == A_ALO;

  wire restart = wr_lo || wr_alo;
  wire lo_acc  = rd_lo || wr_lo;
  wire ext_sel = ctrl[1:0] == 2'b11;

  always_comb begin
    case (ctrl[1:0])
      2'b00:   div_last = 3'd1;
      2'b01:   div_last = 3'd3;
      default: div_last = 3'd7;
    endcase
  end

  wire int_tick = !ext_sel && div == div_last;
  wire ext_edge = ctrl[2] ? (sync[2] && !sync[1]) : (sync[1] && !sync[2]);
  wire tick     = ext_sel ? ext_edge : int_tick;
  wire wrap     = tick && cnt == TOP && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], ext_clk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RELOAD;
      div <= '0;
    end else if (restart) begin
      cnt <= RELOAD;
      div <= '0;
    end else begin
      div <= (wr_ctrl || int_tick) ? 3'd0 : div + 3'd1;
      if (tick) cnt <= cnt + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= bus_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (wrap)                 ovf_flag <= 1'b1;
      else if (lo_acc && armed) ovf_flag <= 1'b0;
      if (lo_acc)       armed <= 1'b0;
      else if (rd_stat) armed <= ovf_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_n <= '0; vld_n <= 1'b0;
      shd_a <= '0; vld_a <= 1'b0;
    end else if (restart) begin
      vld_n <= 1'b0;
      vld_a <= 1'b0;
    end else begin
      if (rd_hi) begin
        shd_n <= cnt[7:0]; vld_n <= 1'b1;
      end else if (rd_lo) vld_n <= 1'b0;
      if (rd_ahi) begin
        shd_a <= cnt[7:0]; vld_a <= 1'b1;
      end else if (rd_alo) vld_a <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_HI, A_AHI: bus_rdata = cnt[15:8];
      A_LO:        bus_rdata = vld_n ? shd_n : cnt[7:0];
      A_ALO:       bus_rdata = vld_a ? shd_a : cnt[7:0];
      A_STAT:      bus_rdata = {ovf_flag, 7'd0};
      A_CTRL:      bus_rdata = {4'd0, ctrl};
      default:     bus_rdata = 8'd0;
    endcase
  end

  assign irq_o = ovf_flag && ctrl[3];

endmodule

// File: rtl/freerun_timer_chk.sv
module freerun_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [15:0] cnt,
  input logic        flag
);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (cnt == 16'hFFFC && !flag));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 16'd1 || cnt == 16'hFFFC));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd3)) |=> cnt == 16'hFFFC);

  assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'h0000 && $past(cnt) == 16'hFFFF) |-> flag);

  assert_alt_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr == 3'd3 && flag) |=> flag);

  assert_clear_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(bus_sel && (bus_rd || bus_wr) && bus_addr == 3'd1));

endmodule

bind freerun_timer freerun_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .cnt(cnt), .flag(ovf_flag)
);

// File: tb/tb_freerun_timer.sv
`timescale 1ns/1ps
module tb_freerun_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  freerun_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {alt_view[26], clk_sel[25:24], edges_waited[23:16], expected_count[15:0]}
  localparam logic [26:0] VEC [11] = '{
    {1'b0, 2'd0, 8'd0,  16'hFFFC},
    {1'b0, 2'd0, 8'd1,  16'hFFFC},
    {1'b1, 2'd0, 8'd2,  16'hFFFD},
    {1'b0, 2'd0, 8'd7,  16'hFFFF},
    {1'b1, 2'd0, 8'd8,  16'h0000},
    {1'b0, 2'd1, 8'd3,  16'hFFFC},
    {1'b1, 2'd1, 8'd4,  16'hFFFD},
    {1'b0, 2'd1, 8'd13, 16'hFFFF},
    {1'b1, 2'd2, 8'd7,  16'hFFFC},
    {1'b0, 2'd2, 8'd8,  16'hFFFD},
    {1'b1, 2'd2, 8'd40, 16'h0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic alt, output logic [15:0] v);
    logic [7:0] h, l;
    rd(alt ? 3'd2 : 3'd0, h);
    rd(alt ? 3'd3 : 3'd1, l);
    v = {h, l};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;

    idle(1);
    chk("R8 irq in reset", irq_o, 1'b0);
    do_reset();
    rd16(1'b0, v);         chk("R1 reset count", v, 16'hFFFC);
    rd(3'd4, b);           chk("R1 reset status", b, 8'h00);
    rd(3'd5, b);           chk("R1 reset control", b, 8'h00);
    chk("R1 reset irq", irq_o, 1'b0);

    // Vector walk: R2 division, R3 restart from either low byte, R9 both views
    for (int i = 0; i < 11; i++) begin
      wr(3'd5, {6'd0, VEC[i][25:24]});
      wr(VEC[i][26] ? 3'd3 : 3'd1, 8'hA5);
      idle(int'(VEC[i][23:16]));
      rd16(VEC[i][26], v);
      chk($sformatf("R2 R3 R9 vector %0d", i), v, VEC[i][15:0]);
    end

    // R10 control readback, unused address
    wr(3'd5, 8'hFD);
    rd(3'd5, b);           chk("R10 control readback", b, 8'h0D);
    rd(3'd7, b);           chk("R10 unused address", b, 8'h00);

    // R3 high byte write ignored
    do_reset();
    wr(3'd5, 8'h02);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h12);
    rd16(1'b0, v);         chk("R3 high write ignored", v, 16'hFFFC);
    wr(3'd2, 8'h34);
    rd16(1'b1, v);         chk("R3 alt high write ignored", v, 16'hFFFC);

    // R9 shadow holds across time
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h00);
    rd(3'd0, b);           chk("R9 high byte", b, 8'hFF);
    idle(10);
    rd(3'd1, b);           chk("R9 normal shadow", b, 8'hFC);
    wr(3'd3, 8'h00);
    rd(3'd2, b);
    idle(10);
    rd(3'd3, b);           chk("R9 alt shadow", b, 8'hFC);

    // R4 external clock, rising edge
    do_reset();
    wr(3'd5, 8'h03);
    wr(3'd1, 8'h00);
    ext_clk_i = 1'b1;
    idle(2);
    rd16(1'b0, v);         chk("R4 latency before third edge", v, 16'hFFFC);
    rd16(1'b0, v);         chk("R4 rising counted", v, 16'hFFFD);
    ext_clk_i = 1'b0; idle(4);
    ext_clk_i = 1'b1; idle(4);
    ext_clk_i = 1'b0; idle(4);
    rd16(1'b0, v);         chk("R4 rising only", v, 16'hFFFE);
    wr(3'd5, 8'h07);
    wr(3'd1, 8'h00);
    ext_clk_i = 1'b1; idle(4);
    rd16(1'b1, v);         chk("R4 rising ignored in falling mode", v, 16'hFFFC);
    ext_clk_i = 1'b0; idle(4);
    rd16(1'b1, v);         chk("R4 falling counted", v, 16'hFFFD);

    // R5 R6 R8 overflow flag and its clearing sequence
    do_reset();
    wr(3'd5, 8'h08);
    wr(3'd1, 8'h00);
    idle(7);
    chk("R5 no flag before wrap", irq_o, 1'b0);
    idle(1);
    chk("R5 R8 wrap raises irq", irq_o, 1'b1);
    rd(3'd3, b);
    chk("R6 alt low read keeps flag", irq_o, 1'b1);
    rd(3'd1, b);
    chk("R6 unarmed normal low keeps flag", irq_o, 1'b1);
    wr(3'd5, 8'h00);
    chk("R8 enable off masks irq", irq_o, 1'b0);
    rd(3'd4, b);           chk("R5 status flag bit7", b, 8'h80);
    rd(3'd3, b);
    wr(3'd5, 8'h08);
    chk("R6 armed alt read keeps flag", irq_o, 1'b1);
    rd(3'd1, b);
    chk("R6 armed normal low clears", irq_o, 1'b0);
    rd(3'd4, b);           chk("R6 status after clear", b, 8'h00);

    // R7 clearing access on the wrap edge
    wr(3'd1, 8'h00);
    idle(8);
    chk("R5 second wrap", irq_o, 1'b1);
    rd(3'd4, b);
    wr(3'd3, 8'h00);
    idle(7);
    rd(3'd1, b);
    chk("R7 wrap beats clear", irq_o, 1'b1);
    rd(3'd4, b);           chk("R7 status still set", b, 8'h80);
    rd(3'd1, b);
    chk("R6 clear after collision", irq_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule